// File: doc/BRIEF.md
# Secure configuration memory controller

This block manages a small byte-wide configuration store that can be reached in two ways. In readout mode, an external readout clock steps a bit counter and an address counter. Stored bits leave on a serial data line, which is modelled as a data output plus a driver-enable output. In programming mode, a simple byte port writes and reads the store. The same port also reaches a one-bit security fuse, which appears as four byte locations at a reserved high address.

When the fuse is set, the serial driver stays off, so stored data can no longer be read out. Any attempt to clear a set fuse wipes the whole store to FF. During the wipe a busy flag is raised. The fuse only drops after two consecutive all-zero fuse writes. After that it also needs a rising edge on the mode pin or a reset. A single stray write in between withdraws the request. The fuse state survives an ordinary reset.

Top module: `cfgmem_secure_ctrl`

## Requirements
- R1: The byte port acts only while `ser_en_i` is low. While it is high, a read produces no `rvalid_o` pulse and a write leaves the store unchanged.
- R2: `sdo_oe_o` is 1 only when `ser_en_i` is 1, `ce_n_i` is 0, `oe_rst_i` is 0 and the fuse is clear. Whenever `sdo_oe_o` is 0, `sdo_o` is 0.
- R3: In readout mode with `ce_n_i` low, a clock edge with `oe_rst_i` high returns both counters to zero. The next bit shown is bit 7 of byte 0.
- R4: In readout mode with `ce_n_i` high, both counters hold and readout clock edges are ignored. In that state `low_pwr_o` is 1. In programming mode `low_pwr_o` is 0 whatever `ce_n_i` is.
- R5: Each rising edge of `rd_clk_i` in readout mode (chip enabled, `oe_rst_i` low) advances the bit index. Bits go out MSB first. After bit 0 of a byte, the address moves up by one and wraps from 2^ADDR_W-1 to 0.
- R6: In programming mode, a write to an address below 2^ADDR_W stores the byte. A read returns the byte with `rvalid_o` high in the cycle after the request. Addresses that are neither in the array nor in the fuse window read as 00, and writes to them have no effect.
- R7: The fuse window is the four addresses 0x800000 to 0x800003. Each of them reads FF while the fuse is set and 00 while it is clear.
- R8: Writing FF to offsets 0, 1, 2 and 3 of the fuse window, in that order, sets the fuse at the fourth write.
- R9: While the fuse is set, `sdo_oe_o` stays 0 in every mode.
- R10: A complete all-00 group of four fuse writes, made while the fuse is set and no clear is already pending, starts an erase. `busy_o` is high for max(ERASE_CYCLES, 2^ADDR_W) cycles starting right after the fourth write, every array byte ends as FF, and the fuse stays set.
- R11: Writes presented while `busy_o` is high are ignored, both by the array and by the fuse sequence.
- R12: A second all-00 group that directly follows the first arms the clear and starts no new erase. The fuse still reads FF until `ser_en_i` rises or a reset is applied, and only then reads 00. A reset while the clear is not armed leaves a set fuse set.
- R13: Any accepted write other than the next byte of the expected 00 group withdraws a pending or armed clear. A later rising edge of `ser_en_i` then leaves the fuse set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the fuse and the array keep their contents |
| ser_en_i | input | 1 | Mode select: 1 readout, 0 programming |
| ce_n_i | input | 1 | Active-low chip enable for readout |
| oe_rst_i | input | 1 | High clears counters; low (with chip enabled) enables the driver |
| rd_clk_i | input | 1 | Readout clock, rising edges are detected on `clk` |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Driver enable for `sdo_o` (0 means high impedance) |
| low_pwr_o | output | 1 | Deselected low-power indication |
| wr_en_i | input | 1 | Byte port write request |
| rd_en_i | input | 1 | Byte port read request |
| addr_i | input | 24 | Byte port address |
| wdata_i | input | 8 | Byte port write data |
| rdata_o | output | 8 | Byte port read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| busy_o | output | 1 | Erase in progress |

## Verification
The bench builds the block with ADDR_W = 3 and ERASE_CYCLES = 12. An eight-byte array lets 64 readout clocks walk the address counter through its wrap back to byte 0. The erase length is then set by ERASE_CYCLES rather than by the array size, so the bench can count the busy window exactly. With these sizes the bench can afford several full erase, arm, cancel and clear sequences, ending once with a mode-pin toggle and once with a reset.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

    localparam int unsigned PADDR_W = 24;
    localparam logic [PADDR_W-1:0] FUSE_BASE = 24'h800000;
    localparam logic [7:0] FUSE_ON_BYTE  = 8'hFF;
    localparam logic [7:0] FUSE_OFF_BYTE = 8'h00;
    localparam logic [7:0] ERASED_BYTE   = 8'hFF;

    typedef enum logic [1:0] {
        CLR_IDLE,
        CLR_ONE,
        CLR_ARMED
    } clr_state_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ARRAY,
        TGT_FUSE
    } tgt_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [PADDR_W-1:0] addr;
        logic [7:0]         data;
    } prog_req_t;

    function automatic tgt_e decode_target(input logic [PADDR_W-1:0] a,
                                           input int unsigned depth);
        tgt_e t;
        if (a[PADDR_W-1:2] == FUSE_BASE[PADDR_W-1:2]) t = TGT_FUSE;
        else if (32'(a) < depth)                     t = TGT_ARRAY;
        else                                          t = TGT_NONE;
        return t;
    endfunction

endpackage

// File: rtl/cfgmem_store.sv
module cfgmem_store
    import cfgmem_pkg::*;
#(
    parameter int unsigned ADDR_W       = 6,
    parameter int unsigned ERASE_CYCLES = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic              erase_start_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    output logic [7:0]        rdata_a_o,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [7:0]        rdata_b_o,
    output logic              busy_o
);
    localparam int unsigned DEPTH     = 1 << ADDR_W;
    localparam int unsigned ERASE_LEN = (ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH;
    localparam int unsigned CNT_W     = $clog2(ERASE_LEN + 1);

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (erase_start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(ERASE_LEN - 1)) busy_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (busy_q && (32'(cnt_q) < DEPTH))
            mem[cnt_q[ADDR_W-1:0]] <= ERASED_BYTE;
        else if (wr_en_i && !busy_q)
            mem[waddr_i] <= wdata_i;
    end

    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
    assign busy_o    = busy_q;

    // R11: the decoder upstream must never pass a write during an erase
    p_wr_not_busy_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |-> !busy_q);

    // R10: erase window never runs past its length
    p_busy_bounded_r10: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (32'(cnt_q) < ERASE_LEN));

    // R10: a new erase is only requested while idle
    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        erase_start_i |-> !busy_q);

endmodule

// File: rtl/cfgmem_fuse.sv
module cfgmem_fuse
    import cfgmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic       fuse_hit_i,
    input  logic [1:0] off_i,
    input  logic [7:0] wdata_i,
    input  logic       ser_rise_i,
    output logic       fuse_o,
    output logic       erase_start_o
);
    logic       fuse_q = 1'b0;
    clr_state_e st_q;
    logic [1:0] idx_q;
    logic [7:0] val_q;

    logic       byte_ok;
    logic       grp_done;
    logic [7:0] grp_val;

    always_comb begin
        grp_val  = (idx_q == 2'd0) ? wdata_i : val_q;
        byte_ok  = fuse_hit_i && (off_i == idx_q) && (wdata_i == grp_val) &&
                   ((wdata_i == FUSE_ON_BYTE) || (wdata_i == FUSE_OFF_BYTE));
        grp_done = wr_i && byte_ok && (idx_q == 2'd3);
        erase_start_o = grp_done && (grp_val == FUSE_OFF_BYTE) && fuse_q &&
                        (st_q != CLR_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (st_q == CLR_ARMED) fuse_q <= 1'b0;
            st_q  <= CLR_IDLE;
            idx_q <= '0;
            val_q <= '0;
        end else if (wr_i) begin
            if (byte_ok) begin
                idx_q <= idx_q + 2'd1;
                if (idx_q == 2'd0) val_q <= wdata_i;
                if (st_q == CLR_ARMED) st_q <= CLR_IDLE;
                if (grp_done) begin
                    if (grp_val == FUSE_ON_BYTE) begin
                        fuse_q <= 1'b1;
                        st_q   <= CLR_IDLE;
                    end else if (fuse_q) begin
                        st_q <= (st_q == CLR_ONE) ? CLR_ARMED : CLR_ONE;
                    end
                end
            end else begin
                idx_q <= '0;
                st_q  <= CLR_IDLE;
            end
        end else if (ser_rise_i && (st_q == CLR_ARMED)) begin
            fuse_q <= 1'b0;
            st_q   <= CLR_IDLE;
        end
    end

    assign fuse_o = fuse_q;

    // R12: an armed clear only exists for a set fuse
    p_armed_set_r12: assert property (@(posedge clk) disable iff (rst)
        (st_q == CLR_ARMED) |-> fuse_q);

    // R12: the fuse only drops out of the armed state
    p_clear_needs_arm_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(fuse_q) |-> ($past(st_q) == CLR_ARMED));

    // R8: the fuse only rises on an accepted FF fuse write
    p_set_by_ff_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fuse_q) |-> $past(wr_i && fuse_hit_i && (wdata_i == FUSE_ON_BYTE)));

endmodule

// File: rtl/cfgmem_readout.sv
module cfgmem_readout #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_mode_i,
    input  logic              ce_n_i,
    input  logic              oe_rst_i,
    input  logic              rd_clk_i,
    input  logic              fuse_i,
    input  logic [7:0]        byte_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              low_pwr_o
);
    logic [2:0]        bit_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_clk_q;
    logic              step;
    logic              active;

    assign step   = rd_clk_i && !rd_clk_q;
    assign active = rd_mode_i && !ce_n_i;

    always_ff @(posedge clk) begin
        rd_clk_q <= rd_clk_i;
        if (rst) begin
            bit_q  <= '0;
            addr_q <= '0;
        end else if (active) begin
            if (oe_rst_i) begin
                bit_q  <= '0;
                addr_q <= '0;
            end else if (step) begin
                bit_q <= bit_q + 3'd1;
                if (bit_q == 3'd7) addr_q <= addr_q + 1'b1;
            end
        end
    end

    assign addr_o    = addr_q;
    assign sdo_oe_o  = active && !oe_rst_i && !fuse_i;
    assign sdo_o     = sdo_oe_o ? byte_i[3'd7 - bit_q] : 1'b0;
    assign low_pwr_o = rd_mode_i && ce_n_i;

    // R4: deselected readout holds both counters
    p_hold_deselect_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_mode_i && ce_n_i) |=> ($stable(bit_q) && $stable(addr_q)));

    // R3: counter clear under oe_rst
    p_clear_counters_r3: assert property (@(posedge clk) disable iff (rst)
        (active && oe_rst_i) |=> ((bit_q == 3'd0) && (addr_q == '0)));

endmodule

// File: rtl/cfgmem_secure_ctrl.sv
module cfgmem_secure_ctrl
    import cfgmem_pkg::*;
#(
    parameter int unsigned ADDR_W       = 6,
    parameter int unsigned ERASE_CYCLES = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_en_i,
    input  logic               ce_n_i,
    input  logic               oe_rst_i,
    input  logic               rd_clk_i,
    output logic               sdo_o,
    output logic               sdo_oe_o,
    output logic               low_pwr_o,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [PADDR_W-1:0] addr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    output logic               rvalid_o,
    output logic               busy_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    prog_req_t         req;
    tgt_e              tgt;
    logic              wr_acc;
    logic              busy_w;
    logic              fuse_w;
    logic              erase_start_w;
    logic              ser_q;
    logic              ser_rise;
    logic [7:0]        rdata_a_w;
    logic [7:0]        rdata_b_w;
    logic [ADDR_W-1:0] ro_addr_w;
    logic [7:0]        rdata_q;
    logic              rvalid_q;

    always_comb begin
        req.wr   = wr_en_i && !ser_en_i;
        req.rd   = rd_en_i && !ser_en_i;
        req.addr = addr_i;
        req.data = wdata_i;
        tgt      = decode_target(req.addr, DEPTH);
        wr_acc   = req.wr && !busy_w;
    end

    assign ser_rise = ser_en_i && !ser_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q    <= ser_en_i;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            ser_q    <= ser_en_i;
            rvalid_q <= req.rd;
            if (req.rd) begin
                case (tgt)
                    TGT_FUSE:  rdata_q <= fuse_w ? FUSE_ON_BYTE : FUSE_OFF_BYTE;
                    TGT_ARRAY: rdata_q <= rdata_a_w;
                    default:   rdata_q <= '0;
                endcase
            end
        end
    end

    cfgmem_store #(
        .ADDR_W      (ADDR_W),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_acc && (tgt == TGT_ARRAY)),
        .waddr_i      (req.addr[ADDR_W-1:0]),
        .wdata_i      (req.data),
        .erase_start_i(erase_start_w),
        .raddr_a_i    (req.addr[ADDR_W-1:0]),
        .rdata_a_o    (rdata_a_w),
        .raddr_b_i    (ro_addr_w),
        .rdata_b_o    (rdata_b_w),
        .busy_o       (busy_w)
    );

    cfgmem_fuse u_fuse (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (wr_acc),
        .fuse_hit_i   (tgt == TGT_FUSE),
        .off_i        (req.addr[1:0]),
        .wdata_i      (req.data),
        .ser_rise_i   (ser_rise),
        .fuse_o       (fuse_w),
        .erase_start_o(erase_start_w)
    );

    cfgmem_readout #(
        .ADDR_W(ADDR_W)
    ) u_readout (
        .clk      (clk),
        .rst      (rst),
        .rd_mode_i(ser_en_i),
        .ce_n_i   (ce_n_i),
        .oe_rst_i (oe_rst_i),
        .rd_clk_i (rd_clk_i),
        .fuse_i   (fuse_w),
        .byte_i   (rdata_b_w),
        .addr_o   (ro_addr_w),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o),
        .low_pwr_o(low_pwr_o)
    );

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
    assign busy_o   = busy_w;

    // R1: no read response for a request made in readout mode
    p_port_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ser_en_i |=> !rvalid_o);

    // R9: a set fuse never lets the driver on
    p_no_leak_r9: assert property (@(posedge clk) disable iff (rst)
        fuse_w |-> !sdo_oe_o);

endmodule

// File: tb/cfgmem_secure_ctrl_bench.sv
module cfgmem_secure_ctrl_bench;

    localparam int unsigned ADDR_W       = 3;
    localparam int unsigned ERASE_CYCLES = 12;
    localparam int unsigned DEPTH        = 1 << ADDR_W;
    localparam int unsigned ERASE_LEN    = (ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_en = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_rst = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [23:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        sdo, sdo_oe, low_pwr, rvalid, busy;
    logic [7:0]  rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    cfgmem_secure_ctrl #(
        .ADDR_W      (ADDR_W),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_cfgmem_secure_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ser_en_i (ser_en),
        .ce_n_i   (ce_n),
        .oe_rst_i (oe_rst),
        .rd_clk_i (rd_clk),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe),
        .low_pwr_o(low_pwr),
        .wr_en_i  (wr_en),
        .rd_en_i  (rd_en),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .rvalid_o (rvalid),
        .busy_o   (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic prog_wr(input logic [23:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic prog_rd(input logic [23:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic fuse_group(input logic [7:0] d);
        for (int i = 0; i < 4; i++) prog_wr(24'h800000 + 24'(i), d);
    endtask

    task automatic pulse();
        rd_clk = 1'b1; tick();
        rd_clk = 1'b0; tick();
    endtask

    task automatic expect_bit(input logic e, input string tag);
        check(sdo_oe && (sdo == e), tag, {sdo_oe, sdo}, {1'b1, e});
    endtask

    task automatic wait_erase(input string tag);
        int cnt = 0;
        while (busy && cnt < 1000) begin cnt++; tick(); end
        check(cnt == ERASE_LEN, tag, cnt, ERASE_LEN);
    endtask

    task automatic toggle_ser();
        ser_en = 1'b1; tick();
        ser_en = 1'b0; tick();
    endtask

    // monitor: pops the scoreboard on every read response
    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected rvalid", rdata, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata == e, t, rdata, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // reset state
        check(sdo_oe == 1'b0, "R2 reset oe", sdo_oe, 0);
        check(low_pwr == 1'b1, "R4 reset low power", low_pwr, 1);
        check(busy == 1'b0, "R10 reset busy", busy, 0);
        check(rvalid == 1'b0, "R1 reset rvalid", rvalid, 0);

        // programming basics
        ser_en = 1'b0; tick();
        check(low_pwr == 1'b0, "R4 prog mode low power", low_pwr, 0);
        prog_wr(24'h0, 8'hA5);
        prog_wr(24'h1, 8'h3C);
        prog_wr(24'h7, 8'h81);
        prog_wr(24'h000100, 8'h77);
        prog_rd(24'h0, 8'hA5, "R6 read addr0");
        prog_rd(24'h1, 8'h3C, "R6 read addr1");
        prog_rd(24'h7, 8'h81, "R6 read addr7");
        prog_rd(24'h000100, 8'h00, "R6 unmapped read");
        for (int i = 0; i < 4; i++) prog_rd(24'h800000 + 24'(i), 8'h00, "R7 fuse clear");

        // readout
        ser_en = 1'b1; ce_n = 1'b0; oe_rst = 1'b1; tick();
        check(sdo_oe == 1'b0, "R2 oe off under oe_rst", sdo_oe, 0);
        check(sdo == 1'b0, "R2 sdo low when off", sdo, 0);
        oe_rst = 1'b0; tick();
        expect_bit(1'b1, "R3 first bit after clear");
        for (int i = 6; i >= 0; i--) begin
            pulse();
            expect_bit(1'(8'hA5 >> i), "R5 byte0 msb first");
        end
        pulse(); expect_bit(1'b0, "R5 byte1 bit7");
        pulse(); expect_bit(1'b0, "R5 byte1 bit6");
        ce_n = 1'b1; tick();
        check(low_pwr == 1'b1, "R4 deselect low power", low_pwr, 1);
        check(sdo_oe == 1'b0, "R2 deselect oe off", sdo_oe, 0);
        pulse(); pulse();
        ce_n = 1'b0; tick();
        expect_bit(1'b0, "R4 counters held");
        pulse(); expect_bit(1'b1, "R4 resume byte1 bit5");

        // wrap
        oe_rst = 1'b1; tick(); oe_rst = 1'b0; tick();
        for (int i = 0; i < 56; i++) pulse();
        expect_bit(1'b1, "R5 addr7 bit7");
        pulse(); expect_bit(1'b0, "R5 addr7 bit6");
        for (int i = 0; i < 6; i++) pulse();
        expect_bit(1'b1, "R5 addr7 bit0");
        pulse(); expect_bit(1'b1, "R5 wrap addr0 bit7");
        pulse(); expect_bit(1'b0, "R5 wrap addr0 bit6");

        // port inactive in readout mode
        prog_wr(24'h1, 8'h00);
        rd_en = 1'b1; addr = 24'h1; tick(); rd_en = 1'b0;
        check(rvalid == 1'b0, "R1 no read in readout mode", rvalid, 0);
        ser_en = 1'b0; ce_n = 1'b1; tick();
        prog_rd(24'h1, 8'h3C, "R1 write ignored in readout mode");

        // set fuse
        fuse_group(8'hFF);
        for (int i = 0; i < 4; i++) prog_rd(24'h800000 + 24'(i), 8'hFF, "R8 fuse set reads FF");
        ser_en = 1'b1; ce_n = 1'b0; oe_rst = 1'b0; tick();
        check(sdo_oe == 1'b0, "R9 readout blocked", sdo_oe, 0);
        ser_en = 1'b0; ce_n = 1'b1; tick();
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        prog_rd(24'h800000, 8'hFF, "R12 fuse survives plain reset");
        prog_rd(24'h0, 8'hA5, "R10 data kept before erase");

        // first clear attempt -> erase
        fuse_group(8'h00);
        check(busy == 1'b1, "R10 busy after attempt", busy, 1);
        prog_wr(24'h2, 8'h55);
        begin
            int cnt = 1;
            while (busy && cnt < 1000) begin cnt++; tick(); end
            check(cnt == ERASE_LEN, "R10 busy length", cnt, ERASE_LEN);
        end
        prog_rd(24'h0, 8'hFF, "R10 addr0 erased");
        prog_rd(24'h2, 8'hFF, "R11 write during busy ignored");
        prog_rd(24'h7, 8'hFF, "R10 addr7 erased");
        prog_rd(24'h800002, 8'hFF, "R10 fuse still set");

        // second group arms, then a stray write cancels
        fuse_group(8'h00);
        check(busy == 1'b0, "R12 no erase on second group", busy, 0);
        prog_rd(24'h800000, 8'hFF, "R12 armed still reads set");
        prog_wr(24'h3, 8'h11);
        toggle_ser();
        prog_rd(24'h800000, 8'hFF, "R13 cancelled clear keeps fuse");
        prog_rd(24'h3, 8'h11, "R13 stray write stored");

        // full clear via mode toggle
        fuse_group(8'h00);
        check(busy == 1'b1, "R10 attempt after cancel erases", busy, 1);
        wait_erase("R10 busy length again");
        fuse_group(8'h00);
        check(busy == 1'b0, "R12 second group no erase", busy, 0);
        toggle_ser();
        prog_rd(24'h800000, 8'h00, "R12 cleared by toggle");
        prog_rd(24'h800003, 8'h00, "R7 fuse byte3 clear");
        prog_wr(24'h0, 8'hA5);
        ser_en = 1'b1; ce_n = 1'b0; oe_rst = 1'b1; tick();
        oe_rst = 1'b0; tick();
        expect_bit(1'b1, "R9 readout restored after clear");
        ser_en = 1'b0; ce_n = 1'b1; tick();

        // full clear via reset
        fuse_group(8'hFF);
        prog_rd(24'h800001, 8'hFF, "R8 fuse set again");
        fuse_group(8'h00);
        wait_erase("R10 busy length third");
        fuse_group(8'h00);
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        prog_rd(24'h800000, 8'h00, "R12 cleared by reset");

        tick(); tick(); tick();
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule